// File: doc/BRIEF.md
# Asynchronous Host Memory Access Port

This block lets an external host that runs without the processor clock read and write the on-chip program memory (24-bit words) and data memory (16-bit words) over a single 16-bit bus that carries both address and data. The host first latches a start address and a memory-select bit with an address strobe. It then issues read or write strobes. Each strobe is brought into the processor clock domain through a flop chain, and its leading edge starts one access. After a completed word the address steps forward, so a block of consecutive words needs only its start address.

Program words are wider than the bus, so each one takes two host transfers. The high 16 bits go first and the low byte follows. A handshake output tells the host when an access is under way and when it has finished. A hold output keeps the core from running in host-load mode until program location 0 has been fully written. The top of data memory holds control registers, and the port can never reach them.

Top module: `host_mem_port`

## Requirements
- R1: After reset, `host_ack` is 1, `host_ad_o` is 0, `host_ad_oe` is 0, no memory request is issued, and `boot_hold` equals `host_boot`.
- R2: On a falling edge of `host_alatch` the port takes bus bits [13:0] as the word address and bit 14 as the memory select (1 = program memory, 0 = data memory). Bit 15 is ignored, and the half-word phase is reset.
- R3: A read or write strobe (`host_sel_n` low together with `host_rd_n` or `host_wr_n` low), driven between clock edges, makes `host_ack` low after the 3rd rising edge. `host_ack` is high again after the 5th rising edge. The edge in between is the single memory cycle.
- R4: A data-memory write stores the 16-bit bus word at the latched address. A data-memory read returns the stored word on `host_ad_o`. Each takes one memory access.
- R5: A program-memory write takes two transfers: the first gives word bits [23:8], and the second gives bits [7:0] in bus bits [7:0], with bus bits [15:8] ignored. Memory is written only during the second transfer.
- R6: A program-memory read takes two transfers and one memory read. The first returns word bits [23:8]; the second returns {8'h00, word bits [7:0]}.
- R7: The address increments after every data-memory access and after the second half of every program word. It wraps from 14'h3FFF to 0.
- R8: Data-memory addresses at or above CTRL_BASE (default 14'h3FE0) are never accessed. Writes there are dropped, reads return 0, and the address still increments.
- R9: `boot_hold` stays high while `host_boot` is 1 until both halves of program location 0 have been written. A first half alone does not release it.
- R10: When an address-latch fall and a data-strobe edge are detected in the same cycle, the access uses the newly latched address. A latch also overrides any increment in the same cycle.
- R11: A strobe held active starts only one access. A new access needs the strobe to go inactive and active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_boot | input | 1 | 1 = core waits for a host load of program location 0 |
| host_ad_i | input | 16 | Multiplexed address/data from host |
| host_ad_o | output | 16 | Read data toward host |
| host_ad_oe | output | 1 | Drive enable for `host_ad_o` (select and read low) |
| host_alatch | input | 1 | Address strobe; the falling edge latches the address |
| host_sel_n | input | 1 | Port select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_ack | output | 1 | 1 = ready for a new strobe; 0 = access in flight |
| boot_hold | output | 1 | Holds core execution |
| pm_req | output | 1 | Program memory access request |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 14 | Program memory word address |
| pm_wdata | output | 24 | Program memory write word |
| pm_rdata | input | 24 | Program memory read word, valid one cycle after request |
| dm_req | output | 1 | Data memory access request |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 14 | Data memory word address |
| dm_wdata | output | 16 | Data memory write word |
| dm_rdata | input | 16 | Data memory read word, valid one cycle after request |

## Verification
The address latch and the start of a data access can land in the same processor cycle, because both strobes pass through synchronizer chains of equal depth. The bench provokes this by dropping `host_alatch` at the same moment it asserts select and read, after first pointing the port at a different address that holds a different word. The read is judged correct only if it returns the word at the newly latched address. A second read must then return the word at that address plus one, which shows the latch fed the increment.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_FIN  = 2'd2
    } hmp_state_e;

    localparam int HMP_SYNC_DEPTH = 2;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
    parameter int W      = 3,
    parameter int STAGES = hmp_pkg::HMP_SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hmp_edge.sv
module hmp_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    logic prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    if (FALLING) begin : g_fall
        assign pulse_o = prev_q & ~level_i;
    end else begin : g_rise
        assign pulse_o = level_i & ~prev_q;
    end

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/hmp_engine.sv
module hmp_engine
    import hmp_pkg::*;
#(
    parameter int                ADDR_W    = 14,
    parameter int                HOST_W    = 16,
    parameter int                PM_W      = 24,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_fall_i,
    input  logic              acc_rise_i,
    input  logic              wr_lvl_i,
    input  logic [HOST_W-1:0] bus_i,
    output logic [HOST_W-1:0] rd_out_o,
    output logic              ack_o,
    output logic              boot_done_o,
    output logic              pm_req,
    output logic              pm_we,
    output logic [ADDR_W-1:0] pm_addr,
    output logic [PM_W-1:0]   pm_wdata,
    input  logic [PM_W-1:0]   pm_rdata,
    output logic              dm_req,
    output logic              dm_we,
    output logic [ADDR_W-1:0] dm_addr,
    output logic [HOST_W-1:0] dm_wdata,
    input  logic [HOST_W-1:0] dm_rdata
);
    localparam int LO_W  = PM_W - HOST_W;
    localparam int PAD_W = HOST_W - LO_W;

    typedef struct packed {
        hmp_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              is_pm;
        logic              half;
        logic              op_wr;
        logic [HOST_W-1:0] wdat;
        logic [HOST_W-1:0] hi;
        logic [LO_W-1:0]   lo;
        logic [HOST_W-1:0] rd_out;
        logic              ack;
        logic              boot_done;
    } eng_t;

    eng_t q, d;
    logic blocked;

    always_comb begin
        d       = q;
        pm_req  = 1'b0;
        pm_we   = 1'b0;
        dm_req  = 1'b0;
        dm_we   = 1'b0;
        blocked = !q.is_pm && (q.addr >= CTRL_BASE);

        case (q.st)
            ST_IDLE: begin
                if (acc_rise_i) begin
                    d.st    = ST_MEM;
                    d.ack   = 1'b0;
                    d.op_wr = wr_lvl_i;
                    d.wdat  = bus_i;
                end
            end
            ST_MEM: begin
                d.st = ST_FIN;
                if (q.is_pm) begin
                    if (q.op_wr) begin
                        if (!q.half) begin
                            d.hi = q.wdat;
                        end else begin
                            pm_req = 1'b1;
                            pm_we  = 1'b1;
                            if (q.addr == '0) d.boot_done = 1'b1;
                        end
                    end else if (!q.half) begin
                        pm_req = 1'b1;
                    end
                end else if (!blocked) begin
                    dm_req = 1'b1;
                    dm_we  = q.op_wr;
                end
            end
            ST_FIN: begin
                d.st  = ST_IDLE;
                d.ack = 1'b1;
                if (!q.op_wr) begin
                    if (q.is_pm) begin
                        if (!q.half) begin
                            d.rd_out = pm_rdata[PM_W-1:LO_W];
                            d.lo     = pm_rdata[LO_W-1:0];
                        end else begin
                            d.rd_out = {{PAD_W{1'b0}}, q.lo};
                        end
                    end else begin
                        d.rd_out = blocked ? '0 : dm_rdata;
                    end
                end
                if (q.is_pm) begin
                    d.half = !q.half;
                    if (q.half) d.addr = q.addr + 1'b1;
                end else begin
                    d.addr = q.addr + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (lat_fall_i) begin
            d.addr  = bus_i[ADDR_W-1:0];
            d.is_pm = bus_i[ADDR_W];
            d.half  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.ack <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pm_addr     = q.addr;
    assign pm_wdata    = {q.hi, q.wdat[LO_W-1:0]};
    assign dm_addr     = q.addr;
    assign dm_wdata    = q.wdat;
    assign rd_out_o    = q.rd_out;
    assign ack_o       = q.ack;
    assign boot_done_o = q.boot_done;

    // R3
    ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> !ack_o);

    // R3
    ack_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> ($past(q.st) == ST_FIN));

    // R8
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req |-> (dm_addr < CTRL_BASE));

    // R4
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_req && dm_req));

    // R5
    pm_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req && pm_we) |-> q.half);

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FIN && !q.is_pm && !lat_fall_i) |=>
            (q.addr == ADDR_W'($past(q.addr) + 1'b1)));

    // R9
    boot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_req && pm_we && pm_addr == '0) |=> boot_done_o);
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port #(
    parameter int                ADDR_W      = 14,
    parameter int                HOST_W      = 16,
    parameter int                PM_W        = 24,
    parameter int                SYNC_STAGES = hmp_pkg::HMP_SYNC_DEPTH,
    parameter logic [ADDR_W-1:0] CTRL_BASE   = 14'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_boot,
    input  logic [HOST_W-1:0] host_ad_i,
    output logic [HOST_W-1:0] host_ad_o,
    output logic              host_ad_oe,
    input  logic              host_alatch,
    input  logic              host_sel_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    output logic              host_ack,
    output logic              boot_hold,
    output logic              pm_req,
    output logic              pm_we,
    output logic [ADDR_W-1:0] pm_addr,
    output logic [PM_W-1:0]   pm_wdata,
    input  logic [PM_W-1:0]   pm_rdata,
    output logic              dm_req,
    output logic              dm_we,
    output logic [ADDR_W-1:0] dm_addr,
    output logic [HOST_W-1:0] dm_wdata,
    input  logic [HOST_W-1:0] dm_rdata
);
    localparam int N_STROBE = 3;
    localparam int IDX_LAT  = 2;
    localparam int IDX_ACC  = 1;
    localparam int IDX_WR   = 0;

    logic [N_STROBE-1:0] raw_strobe, sync_strobe;
    logic rd_act, wr_act, lat_fall, acc_rise, boot_done;

    assign rd_act     = ~host_sel_n & ~host_rd_n;
    assign wr_act     = ~host_sel_n & ~host_wr_n;
    assign raw_strobe = {host_alatch, rd_act | wr_act, wr_act};

    hmp_sync #(.W(N_STROBE), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_strobe),
        .sync_o  (sync_strobe)
    );

    hmp_edge #(.FALLING(1'b1)) u_lat_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_strobe[IDX_LAT]),
        .pulse_o (lat_fall)
    );

    hmp_edge #(.FALLING(1'b0)) u_acc_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_strobe[IDX_ACC]),
        .pulse_o (acc_rise)
    );

    hmp_engine #(
        .ADDR_W    (ADDR_W),
        .HOST_W    (HOST_W),
        .PM_W      (PM_W),
        .CTRL_BASE (CTRL_BASE)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .lat_fall_i  (lat_fall),
        .acc_rise_i  (acc_rise),
        .wr_lvl_i    (sync_strobe[IDX_WR]),
        .bus_i       (host_ad_i),
        .rd_out_o    (host_ad_o),
        .ack_o       (host_ack),
        .boot_done_o (boot_done),
        .pm_req      (pm_req),
        .pm_we       (pm_we),
        .pm_addr     (pm_addr),
        .pm_wdata    (pm_wdata),
        .pm_rdata    (pm_rdata),
        .dm_req      (dm_req),
        .dm_we       (dm_we),
        .dm_addr     (dm_addr),
        .dm_wdata    (dm_wdata),
        .dm_rdata    (dm_rdata)
    );

    assign host_ad_oe = rd_act;
    assign boot_hold  = host_boot & ~boot_done;

    // R9
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_boot && $fell(boot_hold)) |-> $past(pm_req && pm_we && pm_addr == '0));
endmodule

// File: tb/host_mem_port_test.sv
module host_mem_port_test;
    localparam int AW = 14;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, host_boot, host_alatch, host_sel_n, host_rd_n, host_wr_n;
    logic [15:0] host_ad_i, host_ad_o, dm_wdata, dm_rdata;
    logic        host_ad_oe, host_ack, boot_hold, pm_req, pm_we, dm_req, dm_we;
    logic [13:0] pm_addr, dm_addr;
    logic [23:0] pm_wdata, pm_rdata;

    host_mem_port uut (
        .clk(clk), .rst_n(rst_n), .host_boot(host_boot),
        .host_ad_i(host_ad_i), .host_ad_o(host_ad_o), .host_ad_oe(host_ad_oe),
        .host_alatch(host_alatch), .host_sel_n(host_sel_n),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_ack(host_ack),
        .boot_hold(boot_hold),
        .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr),
        .pm_wdata(pm_wdata), .pm_rdata(pm_rdata),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata)
    );

    logic [23:0] pm_mem [0:(1<<AW)-1];
    logic [15:0] dm_mem [0:(1<<AW)-1];
    int pm_wcnt = 0, pm_rcnt = 0, dm_wcnt = 0, dm_rcnt = 0;

    always @(posedge clk) begin
        if (pm_req) begin
            if (pm_we) begin pm_mem[pm_addr] <= pm_wdata; pm_wcnt <= pm_wcnt + 1; end
            else pm_rcnt <= pm_rcnt + 1;
        end
        pm_rdata <= pm_mem[pm_addr];
        if (dm_req) begin
            if (dm_we) begin dm_mem[dm_addr] <= dm_wdata; dm_wcnt <= dm_wcnt + 1; end
            else dm_rcnt <= dm_rcnt + 1;
        end
        dm_rdata <= dm_mem[dm_addr];
    end

    int tests = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_latch(input bit pm, input logic [13:0] a, input bit b15);
        @(negedge clk);
        host_alatch = 1'b1;
        host_ad_i   = {b15, pm, a};
        repeat (3) @(negedge clk);
        host_alatch = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_xfer(input bit wr, input logic [15:0] wd,
                             output logic [15:0] rd, input int hold_extra);
        @(negedge clk);
        host_ad_i  = wd;
        host_sel_n = 1'b0;
        if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(host_ack == 1'b0, "R3 ack low after 3rd edge", host_ack, 0);
        repeat (2) @(negedge clk);
        chk(host_ack == 1'b1, "R3 ack high after 5th edge", host_ack, 1);
        rd = host_ad_o;
        repeat (hold_extra) @(negedge clk);
        host_sel_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(host_ack == 1'b1, "R1 ack at reset", host_ack, 1);
        chk(host_ad_o == 16'h0, "R1 read data at reset", host_ad_o, 0);
        chk(host_ad_oe == 1'b0, "R1 oe at reset", host_ad_oe, 0);
        chk(boot_hold == 1'b1, "R1 boot_hold follows host_boot", boot_hold, 1);
        chk((pm_wcnt + pm_rcnt + dm_wcnt + dm_rcnt) == 0, "R1 no request", pm_wcnt + pm_rcnt + dm_wcnt + dm_rcnt, 0);
    endtask

    task automatic t_boot;
        logic [15:0] r;
        int w0;
        w0 = pm_wcnt;
        host_latch(1'b1, 14'h0000, 1'b0);
        host_xfer(1'b1, 16'hABCD, r, 0);
        chk(boot_hold == 1'b1, "R9 hold after first half", boot_hold, 1);
        chk(pm_wcnt == w0, "R5 no write on first half", pm_wcnt - w0, 0);
        host_xfer(1'b1, 16'h77EF, r, 0);
        chk(boot_hold == 1'b0, "R9 hold released", boot_hold, 0);
        chk(pm_mem[0] == 24'hABCDEF, "R5 pm word assembled", pm_mem[0], 24'hABCDEF);
    endtask

    task automatic t_dm;
        logic [15:0] r;
        dm_mem[14'h0124] = 16'h5A5A;
        host_latch(1'b0, 14'h0123, 1'b1);
        host_xfer(1'b1, 16'hBEEF, r, 0);
        chk(dm_mem[14'h0123] == 16'hBEEF, "R4 dm write (R2 bit15 ignored)", dm_mem[14'h0123], 16'hBEEF);
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'h5A5A, "R7 dm read at next address", r, 16'h5A5A);
        host_latch(1'b0, 14'h0123, 1'b0);
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'hBEEF, "R4 dm readback", r, 16'hBEEF);
    endtask

    task automatic t_pm_read;
        logic [15:0] r;
        int r0;
        pm_mem[14'h0200] = 24'h13579B;
        host_latch(1'b1, 14'h0200, 1'b0);
        r0 = pm_rcnt;
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'h1357, "R6 pm read high part", r, 16'h1357);
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'h009B, "R6 pm read low byte", r, 16'h009B);
        chk(pm_rcnt - r0 == 1, "R6 one memory read", pm_rcnt - r0, 1);
    endtask

    task automatic t_wrap;
        logic [15:0] r;
        host_latch(1'b1, 14'h3FFF, 1'b0);
        host_xfer(1'b1, 16'h1234, r, 0);
        host_xfer(1'b1, 16'hFF56, r, 0);
        chk(pm_mem[14'h3FFF] == 24'h123456, "R5 low byte only", pm_mem[14'h3FFF], 24'h123456);
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'hABCD, "R7 wrap to 0 high", r, 16'hABCD);
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'h00EF, "R7 wrap to 0 low", r, 16'h00EF);
    endtask

    task automatic t_ctrl;
        logic [15:0] r;
        int w0, r0;
        dm_mem[14'h3FE0] = 16'hC0DE;
        dm_mem[14'h3FE1] = 16'h9999;
        host_latch(1'b0, 14'h3FDF, 1'b0);
        w0 = dm_wcnt;
        host_xfer(1'b1, 16'h1111, r, 0);
        chk(dm_mem[14'h3FDF] == 16'h1111, "R8 write below base", dm_mem[14'h3FDF], 16'h1111);
        host_xfer(1'b1, 16'h2222, r, 0);
        chk(dm_mem[14'h3FE0] == 16'hC0DE, "R8 control write dropped", dm_mem[14'h3FE0], 16'hC0DE);
        chk(dm_wcnt - w0 == 1, "R8 one write reached memory", dm_wcnt - w0, 1);
        r0 = dm_rcnt;
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'h0000, "R8 control read returns 0", r, 0);
        chk(dm_rcnt == r0, "R8 no read request", dm_rcnt - r0, 0);
    endtask

    task automatic t_same;
        logic [15:0] r;
        dm_mem[14'h0040] = 16'h4040;
        dm_mem[14'h0300] = 16'h3030;
        dm_mem[14'h0301] = 16'h3131;
        host_latch(1'b0, 14'h0040, 1'b0);
        @(negedge clk);
        host_alatch = 1'b1;
        host_ad_i   = {2'b00, 14'h0300};
        repeat (3) @(negedge clk);
        host_alatch = 1'b0;
        host_sel_n  = 1'b0;
        host_rd_n   = 1'b0;
        repeat (3) @(negedge clk);
        chk(host_ack == 1'b0, "R10 ack low", host_ack, 0);
        repeat (2) @(negedge clk);
        chk(host_ack == 1'b1, "R10 ack high", host_ack, 1);
        chk(host_ad_o == 16'h3030, "R10 access uses new address", host_ad_o, 16'h3030);
        host_sel_n = 1'b1; host_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'h3131, "R10 increment from new address", r, 16'h3131);
    endtask

    task automatic t_hold;
        logic [15:0] r;
        int r0;
        dm_mem[14'h0500] = 16'h5000;
        dm_mem[14'h0501] = 16'h5001;
        host_latch(1'b0, 14'h0500, 1'b0);
        r0 = dm_rcnt;
        host_xfer(1'b0, 16'h0000, r, 12);
        chk(r == 16'h5000, "R11 held read data", r, 16'h5000);
        chk(dm_rcnt - r0 == 1, "R11 one access while held", dm_rcnt - r0, 1);
        host_xfer(1'b0, 16'h0000, r, 0);
        chk(r == 16'h5001, "R11 next read after release", r, 16'h5001);
    endtask

    initial begin
        rst_n = 1'b0; host_boot = 1'b1; host_alatch = 1'b0;
        host_sel_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_ad_i = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boot();
        t_dm();
        t_pm_read();
        t_wrap();
        t_ctrl();
        t_same();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule